// File: doc/BRIEF.md
# Receive Frame Ring with Descriptor Table

This block sits behind a receive MAC and lands incoming Ethernet frames, one byte per handshake, in a circular byte store. The store holds 16 KiB by default and both of its pointers wrap at its size. A frame is accepted only when the count of frames already waiting is below its limit and the free room in the ring can hold a worst-case frame. While either test fails, the block holds its input ready low at the start of a frame. Each stored frame fills the next entry of a small descriptor table with its true length and its start position, reported through a fixed window base. The block then bumps the waiting-frame count and pulses a receive-done interrupt.

The host owns the descriptor entries. It hands one to the block by marking it empty. If the entry due next is not marked empty, the incoming frame is still taken off the input but thrown away. The host drains the ring one 32-bit word per read strobe, optionally with the byte order reversed, and a burst is simply a run of strobes. A separate strobe retires one frame from the count. A receiver reset pulse rewinds the pointers, the descriptor index and the count.

Top module: `rx_ring_buffer`

## Requirements
- R1: Frame bytes are written to consecutive ring addresses from the write pointer, wrapping modulo RING_BYTES. The byte at address a sits in lane a mod 4 of word a/4.
- R2: While no frame is in progress and the frame count equals MAX_FRAMES, `in_ready` is low.
- R3: Free space is RING_BYTES minus ((write pointer minus read pointer) mod RING_BYTES), and a value of zero counts as the whole ring. While no frame is in progress and free space is below MIN_SPACE, `in_ready` is low.
- R4: If the current descriptor is not empty when a frame's first byte is accepted, the whole frame is consumed and discarded. No ring byte, descriptor, pointer, count or interrupt changes.
- R5: After a stored frame, the write pointer advances by the frame length rounded up to a multiple of 4, and wraps.
- R6: A stored frame sets its descriptor's length to the unrounded byte count and its pointer to PTR_BASE plus the frame's ring start. It also clears the descriptor's empty flag.
- R7: After a stored frame, the descriptor index steps and wraps at DESC_COUNT, and the frame count rises by one. `rx_done_irq` is high for the one cycle after the edge that took the last byte.
- R8: `host_rd_data` is the word at the read pointer, as {byte+3, byte+2, byte+1, byte+0}; with `swap_en` high it is {byte+0, byte+1, byte+2, byte+3}. Each `host_rd_strobe` advances the read pointer by 4 modulo RING_BYTES.
- R9: A `ctl_reset` pulse clears the write pointer, read pointer, descriptor index and frame count, and abandons a frame in progress. The effect lasts only for that pulse.
- R10: `frame_dec` lowers the frame count by one. If it coincides with a stored frame, the count is unchanged.
- R11: The frame count never goes below 0 or above MAX_FRAMES, and between cycles it moves by at most one except on `ctl_reset`.
- R12: After `rst_n` low, the frame count is 0, every descriptor reads not empty with zero fields, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the frame's final byte |
| in_ready | output | 1 | Byte accepted on this edge when valid |
| rx_done_irq | output | 1 | One-cycle pulse per stored frame |
| host_rd_strobe | input | 1 | Consume the word at the read pointer |
| host_rd_data | output | 32 | Word at the read pointer |
| swap_en | input | 1 | Reverse byte order of read data |
| ctl_reset | input | 1 | Receiver rewind pulse |
| frame_dec | input | 1 | Retire one frame from the count |
| desc_arm | input | 1 | Mark a descriptor empty |
| desc_arm_idx | input | $clog2(DESC_COUNT) | Descriptor to mark |
| desc_sel | input | $clog2(DESC_COUNT) | Descriptor to observe |
| desc_empty | output | 1 | Empty flag of selected descriptor |
| desc_len | output | 16 | Length field of selected descriptor |
| desc_ptr | output | 16 | Pointer field of selected descriptor |
| frame_count | output | $clog2(MAX_FRAMES+1) | Frames waiting in the ring |

## Verification
The bench builds the block with a 256-byte ring, a limit of 4 waiting frames, a 64-byte worst-case space test and 4 descriptors. With these values a few dozen short frames are enough to fill the count, wrap the descriptor index, push the write pointer around the ring and starve the free-space test. Reads then cross the wrap point too. A behavioural model follows every edge, and the ready, interrupt, count, descriptor and read-word outputs are compared with it on every cycle.

// File: rtl/rxr_pkg.sv
// Shared types and helpers for the receive frame ring.
// Assumes frame lengths and descriptor pointers fit in LEN_W bits.
package rxr_pkg;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic             empty;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] ptr;
    } rxr_desc_t;

    // Round a byte count up to the next multiple of four.
    function automatic logic [LEN_W-1:0] round_up4(input logic [LEN_W-1:0] n);
        return (n + LEN_W'(3)) & ~LEN_W'(3);
    endfunction
endpackage

// File: rtl/rxr_admit.sv
// Admission test for a new frame: frame-count limit and worst-case free space.
// Assumes RING_BYTES is a power of two, so pointer subtraction wraps by itself.
module rxr_admit #(
    parameter int RING_BYTES = 16384,
    parameter int MAX_FRAMES = 64,
    parameter int MIN_SPACE  = 1514,
    localparam int PW = $clog2(RING_BYTES),
    localparam int CW = $clog2(MAX_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    input  logic [CW-1:0] frame_cnt,
    output logic          admit_ok
);
    logic [PW-1:0] used;
    logic [PW-1:0] gap;
    logic [PW:0]   free_bytes;

    // Free room in the ring; a zero result stands for the whole ring.
    always_comb begin
        used       = wr_ptr - rd_ptr;
        gap        = PW'(0) - used;
        free_bytes = (gap == '0) ? (PW+1)'(RING_BYTES) : {1'b0, gap};
        admit_ok   = (frame_cnt < CW'(MAX_FRAMES)) &&
                     (free_bytes >= (PW+1)'(MIN_SPACE));
    end

    AST_SPACE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (free_bytes != '0) && (free_bytes <= (PW+1)'(RING_BYTES))) else $error("free space out of range"); // R3
endmodule

// File: rtl/rxr_ring_mem.sv
// Byte-writable ring store built from four byte lanes, with a word read port.
// Assumes RING_BYTES is a multiple of 4. The store has no reset; unwritten bytes are undefined.
module rxr_ring_mem #(
    parameter int RING_BYTES = 16384,
    localparam int PW    = $clog2(RING_BYTES),
    localparam int WORDS = RING_BYTES / 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [PW-1:0] rd_addr,
    input  logic          swap,
    output logic [31:0]   rd_word
);
    logic [7:0] lane_q [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] store [WORDS];

        // Write the byte into the lane its low address bits select.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr[1:0] == 2'(g)))
                store[wr_addr[PW-1:2]] <= wr_byte;
        end

        assign lane_q[g] = store[rd_addr[PW-1:2]];
    end

    for (genvar g = 0; g < 4; g++) begin : g_out
        // Place each lane in the word, reversed when swap is set.
        assign rd_word[8*g +: 8] = swap ? lane_q[3-g] : lane_q[g];
    end
endmodule

// File: rtl/rxr_desc_table.sv
// Descriptor table: the host marks entries empty, the receiver fills and clears them.
// Assumes a commit and an arm of the same entry on one edge leave it empty (arm wins).
module rxr_desc_table
    import rxr_pkg::*;
#(
    parameter int DESC_COUNT = 64,
    localparam int IW = $clog2(DESC_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IW-1:0]    commit_idx,
    input  logic [LEN_W-1:0] commit_len,
    input  logic [LEN_W-1:0] commit_ptr,
    input  logic             arm,
    input  logic [IW-1:0]    arm_idx,
    input  logic [IW-1:0]    cur_idx,
    output logic             cur_empty,
    input  logic [IW-1:0]    sel_idx,
    output rxr_desc_t        sel_desc
);
    rxr_desc_t table_q [DESC_COUNT];

    // Per-entry update: clear on reset, fill on commit, mark empty on arm.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DESC_COUNT; e++) begin
            if (!rst_n) begin
                table_q[e] <= '0;
            end else begin
                if (commit && (commit_idx == IW'(e))) begin
                    table_q[e].len   <= commit_len;
                    table_q[e].ptr   <= commit_ptr;
                    table_q[e].empty <= 1'b0;
                end
                if (arm && (arm_idx == IW'(e)))
                    table_q[e].empty <= 1'b1;
            end
        end
    end

    assign cur_empty = table_q[cur_idx].empty;
    assign sel_desc  = table_q[sel_idx];

    AST_COMMIT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> table_q[commit_idx].empty) else $error("commit to busy descriptor"); // R4
endmodule

// File: rtl/rx_ring_buffer.sv
// Receive frame ring: admits frames, stores bytes in a circular store, fills descriptors,
// keeps the waiting-frame count and pulses an interrupt per stored frame.
// Assumes no frame is longer than MIN_SPACE bytes and that RING_BYTES and DESC_COUNT are powers of two.
module rx_ring_buffer
    import rxr_pkg::*;
#(
    parameter int          RING_BYTES = 16384,
    parameter int          MAX_FRAMES = 64,
    parameter int          MIN_SPACE  = 1514,
    parameter int          DESC_COUNT = 64,
    parameter logic [15:0] PTR_BASE   = 16'h4000,
    localparam int PW = $clog2(RING_BYTES),
    localparam int CW = $clog2(MAX_FRAMES + 1),
    localparam int IW = $clog2(DESC_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          rx_done_irq,
    input  logic          host_rd_strobe,
    output logic [31:0]   host_rd_data,
    input  logic          swap_en,
    input  logic          ctl_reset,
    input  logic          frame_dec,
    input  logic          desc_arm,
    input  logic [IW-1:0] desc_arm_idx,
    input  logic [IW-1:0] desc_sel,
    output logic          desc_empty,
    output logic [15:0]   desc_len,
    output logic [15:0]   desc_ptr,
    output logic [CW-1:0] frame_count
);
    logic [PW-1:0]    wr_ptr, rd_ptr, start_ptr, this_start, mem_addr;
    logic [IW-1:0]    desc_idx;
    logic [CW-1:0]    frame_cnt;
    logic [LEN_W-1:0] byte_cnt, cnt_eff, total_len;
    logic             frame_active, frame_drop, irq_q;
    logic             admit_ok, cur_empty;
    logic             accept, first, drop_now, mem_we, commit;
    rxr_desc_t        sel_desc;

    rxr_admit #(.RING_BYTES(RING_BYTES), .MAX_FRAMES(MAX_FRAMES), .MIN_SPACE(MIN_SPACE)) u_admit (
        .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .frame_cnt(frame_cnt), .admit_ok(admit_ok)
    );

    // Handshake and per-byte decode of the frame in flight.
    always_comb begin
        in_ready   = frame_active | admit_ok;
        accept     = in_valid & in_ready;
        first      = accept & ~frame_active;
        drop_now   = first ? ~cur_empty : frame_drop;
        this_start = first ? wr_ptr : start_ptr;
        cnt_eff    = first ? '0 : byte_cnt;
        total_len  = cnt_eff + LEN_W'(1);
        mem_addr   = this_start + PW'(cnt_eff);
        mem_we     = accept & ~drop_now & ~ctl_reset;
        commit     = mem_we & in_last;
    end

    rxr_ring_mem #(.RING_BYTES(RING_BYTES)) u_mem (
        .clk(clk), .wr_en(mem_we), .wr_addr(mem_addr), .wr_byte(in_data),
        .rd_addr(rd_ptr), .swap(swap_en), .rd_word(host_rd_data)
    );

    rxr_desc_table #(.DESC_COUNT(DESC_COUNT)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_idx(desc_idx), .commit_len(total_len),
        .commit_ptr(PTR_BASE + LEN_W'(this_start)),
        .arm(desc_arm), .arm_idx(desc_arm_idx),
        .cur_idx(desc_idx), .cur_empty(cur_empty),
        .sel_idx(desc_sel), .sel_desc(sel_desc)
    );

    // Frame tracking: start offset, running length, drop decision.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_reset) begin
            frame_active <= 1'b0;
            frame_drop   <= 1'b0;
            start_ptr    <= '0;
            byte_cnt     <= '0;
        end else if (accept) begin
            frame_active <= ~in_last;
            frame_drop   <= drop_now;
            start_ptr    <= this_start;
            byte_cnt     <= total_len;
        end
    end

    // Ring pointers: write advances per stored frame, read per host word.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_reset) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (commit)
                wr_ptr <= this_start + PW'(round_up4(total_len));
            if (host_rd_strobe)
                rd_ptr <= rd_ptr + PW'(4);
        end
    end

    // Descriptor index steps after each stored frame.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_reset)
            desc_idx <= '0;
        else if (commit)
            desc_idx <= (desc_idx == IW'(DESC_COUNT - 1)) ? '0 : desc_idx + IW'(1);
    end

    // Saturating frame count: up on store, down on host retire.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_reset)
            frame_cnt <= '0;
        else if (commit && !frame_dec && (frame_cnt < CW'(MAX_FRAMES)))
            frame_cnt <= frame_cnt + CW'(1);
        else if (!commit && frame_dec && (frame_cnt != '0))
            frame_cnt <= frame_cnt - CW'(1);
    end

    // Interrupt pulse one cycle after each stored frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= commit;
    end

    assign rx_done_irq = irq_q;
    assign frame_count = frame_cnt;
    assign desc_empty  = sel_desc.empty;
    assign desc_len    = sel_desc.len;
    assign desc_ptr    = sel_desc.ptr;

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && frame_cnt == CW'(MAX_FRAMES)) |-> !in_ready) else $error("admitted at full count"); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CW'(MAX_FRAMES)) else $error("count above limit"); // R11
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_reset) && frame_cnt != $past(frame_cnt)) |->
        (frame_cnt == $past(frame_cnt) + CW'(1) || frame_cnt == $past(frame_cnt) - CW'(1))) else $error("count jumped"); // R11
    AST_WR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00) else $error("write pointer unaligned"); // R5
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr[1:0] == 2'b00) else $error("read pointer unaligned"); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_reset) |-> (frame_cnt == '0 && wr_ptr == '0 && rd_ptr == '0 && desc_idx == '0)) else $error("rewind incomplete"); // R9
    AST_FRAME_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cnt_eff < LEN_W'(MIN_SPACE))) else $error("frame longer than worst case"); // R3
endmodule

// File: tb/rx_ring_buffer_bench.sv
`timescale 1ns/1ps
module rx_ring_buffer_bench;
    localparam int R  = 256;
    localparam int MF = 4;
    localparam int MS = 64;
    localparam int D  = 4;
    localparam logic [15:0] PB = 16'h4000;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_last = 0, host_rd_strobe = 0, swap_en = 0;
    logic ctl_reset = 0, frame_dec = 0, desc_arm = 0;
    logic [7:0] in_data = 0;
    logic [1:0] desc_arm_idx = 0, desc_sel = 0;
    logic in_ready, rx_done_irq, desc_empty;
    logic [31:0] host_rd_data;
    logic [15:0] desc_len, desc_ptr;
    logic [2:0] frame_count;

    int total = 0, bad = 0, irq_seen = 0;

    rx_ring_buffer #(.RING_BYTES(R), .MAX_FRAMES(MF), .MIN_SPACE(MS), .DESC_COUNT(D), .PTR_BASE(PB)) u_rx_ring_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .rx_done_irq(rx_done_irq), .host_rd_strobe(host_rd_strobe),
        .host_rd_data(host_rd_data), .swap_en(swap_en), .ctl_reset(ctl_reset),
        .frame_dec(frame_dec), .desc_arm(desc_arm), .desc_arm_idx(desc_arm_idx),
        .desc_sel(desc_sel), .desc_empty(desc_empty), .desc_len(desc_len),
        .desc_ptr(desc_ptr), .frame_count(frame_count)
    );

    always #10 clk = ~clk;

    // Behavioural reference state
    int m_wr, m_rd, m_cnt, m_idx, m_start, m_len;
    bit m_act, m_drop, m_irq;
    byte unsigned mm [R];
    bit mv [R];
    bit d_empty [D];
    int d_len [D], d_ptr [D];

    function automatic int m_free();
        int used, fr;
        used = (m_wr - m_rd + R) % R;
        fr = (R - used) % R;
        if (fr == 0) fr = R;
        return fr;
    endfunction

    function automatic bit m_ready();
        if (m_act) return 1;
        return (m_cnt < MF) && (m_free() >= MS);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit acc, inc;
        acc = in_valid && m_ready();
        inc = 0;
        if (!rst_n) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_idx = 0; m_act = 0; m_drop = 0; m_irq = 0;
            for (int i = 0; i < D; i++) begin d_empty[i] = 0; d_len[i] = 0; d_ptr[i] = 0; end
        end else begin
            if (ctl_reset) begin
                m_wr = 0; m_rd = 0; m_cnt = 0; m_idx = 0; m_act = 0;
            end else begin
                if (acc) begin
                    if (!m_act) begin
                        m_act = 1; m_start = m_wr; m_len = 0; m_drop = !d_empty[m_idx];
                    end
                    if (!m_drop) begin
                        mm[(m_start + m_len) % R] = in_data;
                        mv[(m_start + m_len) % R] = 1;
                    end
                    m_len++;
                    if (in_last) begin
                        m_act = 0;
                        if (!m_drop) begin
                            d_len[m_idx] = m_len;
                            d_ptr[m_idx] = PB + m_start;
                            d_empty[m_idx] = 0;
                            m_idx = (m_idx + 1) % D;
                            m_wr = (m_start + ((m_len + 3) / 4) * 4) % R;
                            inc = 1;
                        end
                    end
                end
                if (host_rd_strobe) m_rd = (m_rd + 4) % R;
                if (inc && !frame_dec) begin
                    if (m_cnt < MF) m_cnt++;
                end else if (!inc && frame_dec && m_cnt > 0) m_cnt--;
            end
            if (desc_arm) d_empty[desc_arm_idx] = 1;
            m_irq = inc;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] w;
            chk(in_ready === m_ready(), "R2 R3 ready", 32'(in_ready), 32'(m_ready()));
            chk(rx_done_irq === m_irq, "R7 irq", 32'(rx_done_irq), 32'(m_irq));
            chk(frame_count === 3'(m_cnt), "R10 count", 32'(frame_count), 32'(m_cnt));
            chk(desc_empty === d_empty[desc_sel], "R6 empty", 32'(desc_empty), 32'(d_empty[desc_sel]));
            chk(desc_len === 16'(d_len[desc_sel]), "R6 len", 32'(desc_len), 32'(d_len[desc_sel]));
            chk(desc_ptr === 16'(d_ptr[desc_sel]), "R6 ptr", 32'(desc_ptr), 32'(d_ptr[desc_sel]));
            if (mv[m_rd] && mv[m_rd+1] && mv[m_rd+2] && mv[m_rd+3]) begin
                w = swap_en ? {mm[m_rd], mm[m_rd+1], mm[m_rd+2], mm[m_rd+3]}
                            : {mm[m_rd+3], mm[m_rd+2], mm[m_rd+1], mm[m_rd]};
                chk(host_rd_data === w, "R1 R8 rd_data", host_rd_data, w);
            end
            if (rx_done_irq) irq_seen++;
        end
    end

    task automatic tick();
        @(negedge clk); #2;
    endtask

    task automatic send(input int len, input int seed, input bit dec_last = 0);
        for (int i = 0; i < len; i++) begin
            in_valid = 1; in_data = 8'(seed + i * 7); in_last = (i == len - 1);
            frame_dec = dec_last && (i == len - 1);
            #1;
            while (!in_ready) tick();
            tick();
        end
        in_valid = 0; in_last = 0; frame_dec = 0;
    endtask

    task automatic arm(input int i);
        desc_arm = 1; desc_arm_idx = 2'(i); tick(); desc_arm = 0;
    endtask

    task automatic rdw();
        host_rd_strobe = 1; tick(); host_rd_strobe = 0;
    endtask

    task automatic dec();
        frame_dec = 1; tick(); frame_dec = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        // R12 reset state, R3 empty ring counts as full room
        chk(in_ready === 1'b1, "R12 R3 ready after reset", 32'(in_ready), 1);
        chk(frame_count === 3'd0, "R12 count", 32'(frame_count), 0);
        desc_sel = 0; #1;
        chk(desc_empty === 1'b0 && desc_len === 16'd0, "R12 descriptor", {desc_empty, desc_len}, 0);

        // R4 frame with no empty descriptor is dropped
        send(6, 1); tick(); tick();
        chk(frame_count === 3'd0, "R4 count", 32'(frame_count), 0);
        chk(irq_seen == 0, "R4 irq", irq_seen, 0);
        chk(desc_empty === 1'b0 && desc_len === 16'd0, "R4 descriptor", {desc_empty, desc_len}, 0);

        for (int i = 0; i < D; i++) arm(i);
        send(5, 10); send(8, 20); send(1, 30); tick();
        desc_sel = 0; #1;
        chk(desc_ptr === PB && desc_len === 16'd5, "R4 R6 first ptr", {desc_ptr, desc_len}, {PB, 16'd5});
        desc_sel = 1; #1;
        chk(desc_ptr === PB + 16'd8, "R5 rounded advance", desc_ptr, PB + 16'd8);
        desc_sel = 2; #1;
        chk(desc_ptr === PB + 16'd16 && desc_len === 16'd1, "R5 R6 third", {desc_ptr, desc_len}, {PB + 16'd16, 16'd1});
        chk(frame_count === 3'd3 && irq_seen == 3, "R7 count and irq", {frame_count, 8'(irq_seen)}, {3'd3, 8'd3});

        // R1 R8 host reads, both byte orders
        chk(host_rd_data === {8'd31, 8'd24, 8'd17, 8'd10}, "R1 R8 first word", host_rd_data, {8'd31, 8'd24, 8'd17, 8'd10});
        rdw(); rdw(); swap_en = 1; #1;
        chk(host_rd_data === {8'd20, 8'd27, 8'd34, 8'd41}, "R8 swapped word", host_rd_data, {8'd20, 8'd27, 8'd34, 8'd41});
        rdw(); swap_en = 0;

        // R2 full count holds ready low; R7 index wrap
        send(10, 40);
        chk(frame_count === 3'd4, "R7 count at limit", 32'(frame_count), 4);
        in_valid = 1; in_data = 8'h55; in_last = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(in_ready === 1'b0, "R2 blocked at limit", 32'(in_ready), 0);
        end
        in_valid = 0; in_last = 0;
        dec();
        chk(frame_count === 3'd3, "R10 decrement", 32'(frame_count), 3);
        arm(0); send(4, 50); tick();
        desc_sel = 0; #1;
        chk(desc_ptr === PB + 16'd32 && desc_len === 16'd4, "R7 wrapped index", {desc_ptr, desc_len}, {PB + 16'd32, 16'd4});

        // R11 no underflow
        repeat (4) dec();
        dec();
        chk(frame_count === 3'd0, "R11 floor", 32'(frame_count), 0);

        // R10 store and retire together
        arm(1); send(3, 60, 1); tick();
        chk(frame_count === 3'd0, "R10 coincident", 32'(frame_count), 0);

        // R3 free-space starvation, with ring wrap
        while (m_free() >= MS) begin
            arm(m_idx); send(60, 70 + m_wr); dec();
        end
        tick();
        chk(in_ready === 1'b0, "R3 low space blocks", 32'(in_ready), 0);
        while (m_free() < MS) rdw();
        tick();
        chk(in_ready === 1'b1, "R3 space regained", 32'(in_ready), 1);
        arm(m_idx); send(60, 90); dec();
        repeat (20) rdw();

        // R9 rewind mid-frame
        arm(m_idx);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1; in_data = 8'(i); in_last = 0; tick();
        end
        in_valid = 0;
        ctl_reset = 1; tick(); ctl_reset = 0; tick();
        chk(frame_count === 3'd0 && in_ready === 1'b1, "R9 rewind", {frame_count, in_ready}, {3'd0, 1'b1});
        arm(0); send(4, 100); tick();
        desc_sel = 0; #1;
        chk(desc_ptr === PB && desc_len === 16'd4, "R9 restart at ring base", {desc_ptr, desc_len}, {PB, 16'd4});
        chk(host_rd_data === {8'd121, 8'd114, 8'd107, 8'd100}, "R9 R1 read from base", host_rd_data, {8'd121, 8'd114, 8'd107, 8'd100});
        tick(); tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule